// File: doc/BRIEF.md
# Byte FIFO Pair with Self-Clearing Flush and Level Thresholds

This block holds the two data queues of a serial bus master. The host writes bytes into a transmit queue and the bus engine drains them. The bus engine fills a receive queue and the host reads from it. Both queues are byte wide and have a parameterised depth, 16 entries by default. Both present their head byte directly on the read data output, so a read strobe consumes the byte already shown.

Each queue has its own flush request. A request starts a flush that lasts a fixed number of cycles. The matching flush bit reads back as 1 for that whole time and then clears without any further action. The contents are discarded at the start of the flush, and the queue ignores all accesses while the flush bit is set.

Level flags for the interrupt logic are formed against two programmable 4-bit thresholds. A host write into a full transmit queue is dropped and raises a sticky overrun flag.

Top module: `fifo_pair_thr`

## Requirements
- R1: After reset both flush bits read 0, both queues are empty, both full flags are 0 and the overrun flag is 0.
- R2: Each queue returns bytes in the order they were accepted. It accepts exactly 16 bytes (DEPTH) before its full flag rises.
- R3: A transmit flush request makes tx_flush_o read 1 from the next cycle on, for exactly FLUSH_CYCLES (4) cycles, after which it reads 0. The queue is empty from the first of those cycles.
- R4: Transmit and receive flushes are independent. Both can be requested in the same cycle, and a flush of one queue leaves the other queue's contents intact.
- R5: While a queue's flush bit reads 1, writes and reads of that queue are ignored.
- R6: tx_nempty_o is 1 exactly when the transmit entry count is less than or equal to tx_thr_i.
- R7: rx_nfull_o is 1 exactly when the receive entry count is greater than or equal to rx_thr_i.
- R8: A host write while the transmit queue is full sets tx_ovr_o. The byte is dropped and the stored bytes are unchanged.
- R9: tx_ovr_o stays 1 until a cycle with tx_ovr_clr_i high. If a new overrun happens in that same cycle, the flag stays 1.
- R10: A read of an empty queue is ignored. A bus push into a full receive queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tx_flush_req_i | input | 1 | Pulse that requests a transmit queue flush |
| rx_flush_req_i | input | 1 | Pulse that requests a receive queue flush |
| tx_flush_o | output | 1 | Transmit flush pending |
| rx_flush_o | output | 1 | Receive flush pending |
| tx_thr_i | input | 4 | Transmit nearly-empty threshold |
| rx_thr_i | input | 4 | Receive nearly-full threshold |
| tx_wr_i | input | 1 | Host write strobe, transmit queue |
| tx_wdata_i | input | 8 | Host write byte |
| tx_rd_i | input | 1 | Bus-side pop strobe, transmit queue |
| tx_rdata_o | output | 8 | Transmit head byte |
| rx_wr_i | input | 1 | Bus-side push strobe, receive queue |
| rx_wdata_i | input | 8 | Received byte |
| rx_rd_i | input | 1 | Host read strobe, receive queue |
| rx_rdata_o | output | 8 | Receive head byte |
| tx_ovr_clr_i | input | 1 | Clears the overrun flag |
| tx_empty_o | output | 1 | Transmit queue empty |
| tx_nempty_o | output | 1 | Transmit count at or below the threshold |
| tx_full_o | output | 1 | Transmit queue full |
| tx_ovr_o | output | 1 | Sticky transmit overrun |
| rx_empty_o | output | 1 | Receive queue empty |
| rx_nfull_o | output | 1 | Receive count at or above the threshold |
| rx_full_o | output | 1 | Receive queue full |

## Verification
Several properties are checked on every cycle:
- A queue reads empty whenever its flush is pending.
- Empty and full are never both set.
- An empty transmit queue always reports nearly empty, and a full receive queue always reports nearly full.
- A write into a full transmit queue raises the overrun flag and leaves the queue full.
- The overrun flag drops only after a clear.
- A flush bit rises only after a request.

Only the scenarios can show the byte order end to end, the exact length of the flush window, the threshold boundaries at particular counts, and that one queue's flush leaves the other queue's bytes intact.

// File: rtl/fifo_pair_pkg.sv
package fifo_pair_pkg;
  localparam int BYTE_W = 8;
  localparam int NCH    = 2;  // channel 0: transmit, 1: receive
  typedef logic [BYTE_W-1:0] byte_t;
endpackage

// File: rtl/flush_ctrl.sv
module flush_ctrl #(
  parameter int CYCLES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic start_o,
  output logic busy_o
);
  localparam int CNTW = (CYCLES > 1) ? $clog2(CYCLES) : 1;

  logic [CNTW-1:0] cnt_q;

  assign start_o = req_i & ~busy_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      cnt_q  <= '0;
    end else if (start_o) begin
      busy_o <= 1'b1;
      cnt_q  <= CNTW'(CYCLES - 1);
    end else if (busy_o) begin
      if (cnt_q == '0) busy_o <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/byte_fifo.sv
module byte_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wr_ptr_q, rd_ptr_q;
  logic          do_push, do_pop;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full_o  = (count_o == CW'(DEPTH));
  assign empty_o = (count_o == '0);
  assign do_push = push_i & ~full_o & ~clr_i;
  assign do_pop  = pop_i & ~empty_o & ~clr_i;
  assign rdata_o = mem_q[rd_ptr_q];

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_o  <= '0;
    end else begin
      if (do_push) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   count_o <= count_o + 1'b1;
        2'b01:   count_o <= count_o - 1'b1;
        default: count_o <= count_o;
      endcase
    end
  end
endmodule

// File: rtl/fifo_pair_thr.sv
module fifo_pair_thr
  import fifo_pair_pkg::*;
#(
  parameter int DEPTH        = 16,
  parameter int THR_W        = 4,
  parameter int FLUSH_CYCLES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_flush_req_i,
  input  logic             rx_flush_req_i,
  output logic             tx_flush_o,
  output logic             rx_flush_o,
  input  logic [THR_W-1:0] tx_thr_i,
  input  logic [THR_W-1:0] rx_thr_i,
  input  logic             tx_wr_i,
  input  logic [7:0]       tx_wdata_i,
  input  logic             tx_rd_i,
  output logic [7:0]       tx_rdata_o,
  input  logic             rx_wr_i,
  input  logic [7:0]       rx_wdata_i,
  input  logic             rx_rd_i,
  output logic [7:0]       rx_rdata_o,
  input  logic             tx_ovr_clr_i,
  output logic             tx_empty_o,
  output logic             tx_nempty_o,
  output logic             tx_full_o,
  output logic             tx_ovr_o,
  output logic             rx_empty_o,
  output logic             rx_nfull_o,
  output logic             rx_full_o
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [NCH-1:0] req, start, busy, clr, push, pop, full, empty;
  byte_t          wdata [NCH];
  byte_t          rdata [NCH];
  logic [CW-1:0]  cnt   [NCH];

  assign req   = {rx_flush_req_i, tx_flush_req_i};
  assign push  = {rx_wr_i & ~busy[1], tx_wr_i & ~busy[0]};
  assign pop   = {rx_rd_i & ~busy[1], tx_rd_i & ~busy[0]};
  assign wdata[0] = tx_wdata_i;
  assign wdata[1] = rx_wdata_i;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    assign clr[g] = start[g] | busy[g];

    flush_ctrl #(.CYCLES(FLUSH_CYCLES)) u_flush (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .req_i   (req[g]),
      .start_o (start[g]),
      .busy_o  (busy[g])
    );

    byte_fifo #(.DEPTH(DEPTH), .DW(BYTE_W)) u_fifo (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clr_i   (clr[g]),
      .push_i  (push[g]),
      .wdata_i (wdata[g]),
      .pop_i   (pop[g]),
      .rdata_o (rdata[g]),
      .count_o (cnt[g]),
      .full_o  (full[g]),
      .empty_o (empty[g])
    );
  end

  // overrun: host write into a full transmit queue; set wins over clear
  logic ovr_set;
  assign ovr_set = push[0] & full[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tx_ovr_o <= 1'b0;
    else         tx_ovr_o <= ovr_set | (tx_ovr_o & ~tx_ovr_clr_i);
  end

  assign tx_flush_o  = busy[0];
  assign rx_flush_o  = busy[1];
  assign tx_rdata_o  = rdata[0];
  assign rx_rdata_o  = rdata[1];
  assign tx_empty_o  = empty[0];
  assign tx_full_o   = full[0];
  assign rx_empty_o  = empty[1];
  assign rx_full_o   = full[1];
  assign tx_nempty_o = cnt[0] <= CW'(tx_thr_i);
  assign rx_nfull_o  = cnt[1] >= CW'(rx_thr_i);
endmodule

// File: rtl/fifo_pair_chk.sv
module fifo_pair_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_flush_req_i,
  input logic rx_flush_req_i,
  input logic tx_flush_o,
  input logic rx_flush_o,
  input logic tx_wr_i,
  input logic tx_rd_i,
  input logic tx_ovr_clr_i,
  input logic tx_empty_o,
  input logic tx_nempty_o,
  input logic tx_full_o,
  input logic tx_ovr_o,
  input logic rx_empty_o,
  input logic rx_nfull_o,
  input logic rx_full_o
);
  // R3
  tx_flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_flush_o |-> tx_empty_o);
  // R4
  rx_flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_flush_o |-> rx_empty_o);
  // R3
  tx_flush_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_flush_o) |-> $past(tx_flush_req_i));
  // R4
  rx_flush_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_flush_o) |-> $past(rx_flush_req_i));
  // R10
  tx_full_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(tx_full_o && tx_empty_o));
  // R10
  rx_full_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rx_full_o && rx_empty_o));
  // R6
  tx_nempty_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_empty_o |-> tx_nempty_o);
  // R7
  rx_nfull_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_full_o |-> rx_nfull_o);
  // R8
  tx_ovr_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_o && tx_wr_i && !tx_flush_o && !tx_flush_req_i) |=> tx_ovr_o);
  // R8
  tx_ovr_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_full_o && tx_wr_i && !tx_rd_i && !tx_flush_o && !tx_flush_req_i) |=> tx_full_o);
  // R9
  tx_ovr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(tx_ovr_o) |-> $past(tx_ovr_clr_i));
endmodule

bind fifo_pair_thr fifo_pair_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_flush_req_i (tx_flush_req_i),
  .rx_flush_req_i (rx_flush_req_i),
  .tx_flush_o     (tx_flush_o),
  .rx_flush_o     (rx_flush_o),
  .tx_wr_i        (tx_wr_i),
  .tx_rd_i        (tx_rd_i),
  .tx_ovr_clr_i   (tx_ovr_clr_i),
  .tx_empty_o     (tx_empty_o),
  .tx_nempty_o    (tx_nempty_o),
  .tx_full_o      (tx_full_o),
  .tx_ovr_o       (tx_ovr_o),
  .rx_empty_o     (rx_empty_o),
  .rx_nfull_o     (rx_nfull_o),
  .rx_full_o      (rx_full_o)
);

// File: tb/tb_fifo_pair_thr.sv
`timescale 1ns/1ps
module tb_fifo_pair_thr;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic       tx_flush_req_i = 0, rx_flush_req_i = 0, tx_flush_o, rx_flush_o;
  logic [3:0] tx_thr_i = 4'd3, rx_thr_i = 4'd5;
  logic       tx_wr_i = 0, tx_rd_i = 0, rx_wr_i = 0, rx_rd_i = 0, tx_ovr_clr_i = 0;
  logic [7:0] tx_wdata_i = 0, rx_wdata_i = 0, tx_rdata_o, rx_rdata_o;
  logic       tx_empty_o, tx_nempty_o, tx_full_o, tx_ovr_o, rx_empty_o, rx_nfull_o, rx_full_o;

  int n_run = 0, n_fail = 0;
  logic [7:0] txq[$], rxq[$];

  always #4 clk_i = ~clk_i;

  fifo_pair_thr dut (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  // monitor: compare popped head bytes against the scoreboard queues (R2)
  always @(negedge clk_i) if (rst_ni) begin
    if (tx_rd_i && !tx_empty_o && !tx_flush_o) begin
      if (txq.size() == 0) chk(0, "R2 tx extra byte", tx_rdata_o, -1);
      else begin
        logic [7:0] e; e = txq.pop_front();
        chk(tx_rdata_o == e, "R2 tx order", tx_rdata_o, e);
      end
    end
    if (rx_rd_i && !rx_empty_o && !rx_flush_o) begin
      if (rxq.size() == 0) chk(0, "R2 rx extra byte", rx_rdata_o, -1);
      else begin
        logic [7:0] e; e = rxq.pop_front();
        chk(rx_rdata_o == e, "R2 rx order", rx_rdata_o, e);
      end
    end
  end

  task automatic host_wr(input logic [7:0] d, input bit expect_keep);
    tx_wr_i = 1; tx_wdata_i = d;
    if (expect_keep) txq.push_back(d);
    tick(); tx_wr_i = 0;
  endtask

  task automatic bus_wr(input logic [7:0] d, input bit expect_keep);
    rx_wr_i = 1; rx_wdata_i = d;
    if (expect_keep) rxq.push_back(d);
    tick(); rx_wr_i = 0;
  endtask

  task automatic drain_tx(input int n);
    for (int i = 0; i < n; i++) begin tx_rd_i = 1; tick(); end
    tx_rd_i = 0;
  endtask

  task automatic drain_rx(input int n);
    for (int i = 0; i < n; i++) begin rx_rd_i = 1; tick(); end
    rx_rd_i = 0;
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    chk(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst_ni = 1; tick();
    // R1
    chk(!tx_flush_o && !rx_flush_o, "R1 flush bits", {tx_flush_o, rx_flush_o}, 0);
    chk(tx_empty_o && rx_empty_o && !tx_full_o && !rx_full_o, "R1 levels",
        {tx_empty_o, rx_empty_o, tx_full_o, rx_full_o}, 4'b1100);
    chk(!tx_ovr_o, "R1 overrun", tx_ovr_o, 0);

    // fill transmit queue, watching nearly-empty against threshold 3
    for (int k = 1; k <= 16; k++) begin
      host_wr(8'(k * 7 + 1), 1);
      if (k == 3) chk(tx_nempty_o == 1, "R6 count 3 thr 3", tx_nempty_o, 1);
      if (k == 4) chk(tx_nempty_o == 0, "R6 count 4 thr 3", tx_nempty_o, 0);
      if (k == 15) chk(!tx_full_o, "R2 not full at 15", tx_full_o, 0);
    end
    chk(tx_full_o, "R2 full at 16", tx_full_o, 1);
    host_wr(8'hEE, 0);
    chk(tx_ovr_o, "R8 overrun set", tx_ovr_o, 1);
    chk(tx_full_o, "R8 still full", tx_full_o, 1);
    drain_tx(16);
    chk(tx_empty_o && txq.size() == 0, "R8 dropped byte absent", txq.size(), 0);
    tx_rd_i = 1; tick(); tx_rd_i = 0;  // R10 read of empty
    chk(tx_empty_o, "R10 tx empty read", tx_empty_o, 1);
    chk(tx_ovr_o, "R9 overrun sticky", tx_ovr_o, 1);
    tx_ovr_clr_i = 1; tick(); tx_ovr_clr_i = 0;
    chk(!tx_ovr_o, "R9 overrun cleared", tx_ovr_o, 0);

    // set wins over clear
    for (int k = 0; k < 16; k++) host_wr(8'(k + 100), 1);
    tx_ovr_clr_i = 1; host_wr(8'h55, 0); tx_ovr_clr_i = 0;
    chk(tx_ovr_o, "R9 set beats clear", tx_ovr_o, 1);
    tx_thr_i = 4'd15;
    #1 chk(!tx_nempty_o, "R6 count 16 thr 15", tx_nempty_o, 0);

    // R3 flush of a full transmit queue
    tx_flush_req_i = 1; txq.delete(); tick(); tx_flush_req_i = 0;
    chk(tx_flush_o && tx_empty_o, "R3 flush started, empty", {tx_flush_o, tx_empty_o}, 3);
    host_wr(8'h77, 0);  // R5: ignored
    tick(); tick();
    chk(tx_flush_o, "R3 flush bit at cycle 4", tx_flush_o, 1);
    tick();
    chk(!tx_flush_o, "R3 flush bit cleared", tx_flush_o, 0);
    chk(tx_empty_o, "R5 write during flush ignored", tx_empty_o, 1);
    chk(tx_nempty_o, "R6 count 0 thr 15", tx_nempty_o, 1);

    // receive queue, nearly-full threshold 5
    for (int k = 1; k <= 16; k++) begin
      bus_wr(8'(k * 13), 1);
      if (k == 4) chk(!rx_nfull_o, "R7 count 4 thr 5", rx_nfull_o, 0);
      if (k == 5) chk(rx_nfull_o, "R7 count 5 thr 5", rx_nfull_o, 1);
    end
    chk(rx_full_o, "R2 rx full at 16", rx_full_o, 1);
    bus_wr(8'hF0, 0);
    chk(rx_full_o, "R10 push into full rx", rx_full_o, 1);
    drain_rx(16);
    chk(rx_empty_o && rxq.size() == 0, "R10 rx drained, extra dropped", rxq.size(), 0);
    rx_rd_i = 1; tick(); rx_rd_i = 0;
    bus_wr(8'hA5, 1);
    drain_rx(1);
    chk(rx_empty_o && rxq.size() == 0, "R10 rx empty read ignored", rxq.size(), 0);
    rx_thr_i = 4'd0;
    #1 chk(rx_nfull_o, "R7 count 0 thr 0", rx_nfull_o, 1);

    // R4 independent flush
    host_wr(8'h11, 1); host_wr(8'h22, 1);
    bus_wr(8'h33, 0); bus_wr(8'h44, 0);
    rx_flush_req_i = 1; rxq.delete(); tick(); rx_flush_req_i = 0;
    chk(rx_flush_o && !tx_flush_o, "R4 only rx flushing", {tx_flush_o, rx_flush_o}, 1);
    chk(rx_empty_o && !tx_empty_o, "R4 tx kept", {tx_empty_o, rx_empty_o}, 1);
    bus_wr(8'h99, 0);  // R5: ignored during rx flush
    repeat (4) tick();
    chk(!rx_flush_o && rx_empty_o, "R5 rx push during flush ignored", rx_empty_o, 1);
    drain_tx(2);
    chk(tx_empty_o && txq.size() == 0, "R4 tx bytes survived", txq.size(), 0);

    host_wr(8'h01, 0); bus_wr(8'h02, 0);
    tx_flush_req_i = 1; rx_flush_req_i = 1; tick();
    tx_flush_req_i = 0; rx_flush_req_i = 0;
    chk(tx_flush_o && rx_flush_o, "R4 both flushing", {tx_flush_o, rx_flush_o}, 3);
    chk(tx_empty_o && rx_empty_o, "R4 both empty", {tx_empty_o, rx_empty_o}, 3);
    repeat (4) tick();
    chk(!tx_flush_o && !rx_flush_o, "R4 both cleared", {tx_flush_o, rx_flush_o}, 0);

    finish_run();
  end
endmodule